// File: doc/BRIEF.md
# Shared-Pin Static RAM Access Controller

This block drives a 256-word by 8-bit static RAM whose data pins serve for both reading and writing, and arbitrates those pins between a shared system bus and a set of manual data switches. Two active-low strobes from the sequencer ask for a read or a write. A mode input selects between normal execution (run mode) and hand loading (program mode). In program mode a push button stores the switch value. The memory array is modelled inside the block.

The chip enable and output enable of the RAM stay asserted. Every write is made by a low pulse on write-enable alone. The block produces that pulse. It also produces enables for a two-way path between the bus and the RAM, a direction bit for that path, and an enable for a one-way path from the switches to the RAM. A bus-drive enable gates the read data onto the bus. A run-mode write lasts only while the clock is high. Read and write strobes together are illegal: an interlock turns that case into a read and raises a flag.

Top module: `sharedRamCtrl`

## Requirements
- R1: `ramCeN` and `ramOeN` are 0 at all times, including during reset.
- R2: In run mode with only `wrN` low, `ramWeN` is 0 exactly while `clk` is 1. `busPathEn` is 1 with `busToBus` 0 during that same interval, and both are 0 while `clk` is 0.
- R3: The array stores a word on the rising edge of `ramWeN`, at the address selected at that moment. The word comes from `busIn` in run mode and from `swData` in program mode.
- R4: In run mode with only `rdN` low, `ramWeN` stays 1, `busPathEn`, `busToBus` and `busDrive` are 1 in both clock phases, and `busOut` equals the stored word at `runAddr`.
- R5: In run mode with both strobes high, `ramWeN` is 1 and `busPathEn`, `swPathEn` and `busDrive` are 0. `progBtn` has no effect in run mode.
- R6: In program mode (`progMode` = 1), `busPathEn`, `busToBus` and `busDrive` are 0 and the strobes cause no write. While `progBtn` is 1, `ramWeN` is 0 and `swPathEn` is 1.
- R7: With `rdN` and `wrN` both low, `illegal` is 1 in either mode. In run mode the block behaves as a read (R4) and stores nothing.
- R8: `busOut` is all zeros whenever `busDrive` is 0.
- R9: While `rstN` is 0, `ramWeN` is 1 and `busPathEn`, `swPathEn` and `busDrive` are 0, whatever the other inputs are.
- R10: The array address is `runAddr` in run mode and `progAddr` in program mode.
- R11: A path toward the RAM (`swPathEn`, or `busPathEn` with `busToBus` 0) is enabled only while `ramWeN` is 0. This way data reaches the pins only after the RAM has turned them to input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; a run-mode write lasts for its high phase |
| rstN | input | 1 | Active-low reset; holds write-enable off and all paths disabled |
| rdN | input | 1 | Active-low read-RAM strobe |
| wrN | input | 1 | Active-low write-RAM strobe |
| progMode | input | 1 | 1 = program (manual) mode, 0 = run mode |
| progBtn | input | 1 | Manual write button, 1 = pressed |
| runAddr | input | 8 | Address from the memory address register |
| progAddr | input | 8 | Address from the manual address switches |
| busIn | input | 8 | Data on the system bus |
| swData | input | 8 | Manual data switches |
| busOut | output | 8 | Read data toward the bus, zero unless driving |
| busDrive | output | 1 | Enable for driving `busOut` onto the bus |
| ramWeN | output | 1 | RAM write-enable, active low |
| ramCeN | output | 1 | RAM chip enable, held 0 |
| ramOeN | output | 1 | RAM output enable, held 0 |
| busPathEn | output | 1 | Enable of the bus-to/from-RAM transceiver path |
| busToBus | output | 1 | Direction of that path, 1 = RAM toward bus |
| swPathEn | output | 1 | Enable of the switch-to-RAM path |
| illegal | output | 1 | Both strobes asserted together |

## Verification
Decode faults appear at the ports in the same clock phase. A write-enable pulse in the wrong phase, or a path enabled in the wrong direction, shows up on `ramWeN`, `busPathEn` or `busToBus` as soon as the strobe or the clock level changes. A write that lands at the wrong address, takes its data from the wrong source, or slips past the interlock stays hidden until a later read returns the wrong word on `busOut`. The bench therefore reads back each stored location, and the locations that must stay unchanged, in the read cycle right after the write.

// File: rtl/sharedRamPkg.sv
package sharedRamPkg;

  // Strobes from the control decoder to the datapath and the pins
  typedef struct packed {
    logic weN;        // RAM write-enable, active low
    logic busPathEn;  // bus transceiver enable
    logic busToBus;   // 1 = RAM toward bus
    logic swPathEn;   // switch transceiver enable
    logic busDrive;   // read data allowed onto the bus
    logic illegal;    // both strobes asserted
  } ramStrobes_t;

endpackage

// File: rtl/sharedRamCtrlDecode.sv
module sharedRamCtrlDecode
  import sharedRamPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        progMode,
  input  logic        progBtn,
  output ramStrobes_t strobes
);

  logic inRun;
  logic rdReq;
  logic wrReq;
  logic runWrite;
  logic progWrite;

  always_comb begin
    inRun     = ~progMode;
    rdReq     = ~rdN;
    // interlock: a write is granted only while the read strobe is idle
    wrReq     = ~wrN & rdN;
    runWrite  = rstN & inRun & wrReq & clk;
    progWrite = rstN & progMode & progBtn;

    strobes.weN       = ~(runWrite | progWrite);
    strobes.busPathEn = rstN & inRun & (rdReq | runWrite);
    strobes.busToBus  = rstN & inRun & rdReq;
    strobes.swPathEn  = progWrite;
    strobes.busDrive  = rstN & inRun & rdReq;
    strobes.illegal   = ~rdN & ~wrN;
  end

endmodule

// File: rtl/sharedRamDatapath.sv
module sharedRamDatapath
  import sharedRamPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  ramStrobes_t       strobes,
  input  logic              progMode,
  input  logic [ADDR_W-1:0] runAddr,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] swData,
  output logic [DATA_W-1:0] busOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;
  logic              weN;

  always_comb begin
    curAddr = progMode ? progAddr : runAddr;
    wrData  = progMode ? swData : busIn;
    weN     = strobes.weN;
    rdData  = memArray[curAddr];
  end

  // the word is captured when write-enable returns high
  always_ff @(posedge weN) begin
    memArray[curAddr] <= wrData;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_busGate
    assign busOut[b] = rdData[b] & strobes.busDrive;
  end

endmodule

// File: rtl/sharedRamCtrl.sv
module sharedRamCtrl
  import sharedRamPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              progMode,
  input  logic              progBtn,
  input  logic [ADDR_W-1:0] runAddr,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] swData,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  output logic              ramWeN,
  output logic              ramCeN,
  output logic              ramOeN,
  output logic              busPathEn,
  output logic              busToBus,
  output logic              swPathEn,
  output logic              illegal
);

  ramStrobes_t strobes;

  sharedRamCtrlDecode u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .rdN      (rdN),
    .wrN      (wrN),
    .progMode (progMode),
    .progBtn  (progBtn),
    .strobes  (strobes)
  );

  sharedRamDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .strobes  (strobes),
    .progMode (progMode),
    .runAddr  (runAddr),
    .progAddr (progAddr),
    .busIn    (busIn),
    .swData   (swData),
    .busOut   (busOut)
  );

  assign ramWeN    = strobes.weN;
  assign busPathEn = strobes.busPathEn;
  assign busToBus  = strobes.busToBus;
  assign swPathEn  = strobes.swPathEn;
  assign busDrive  = strobes.busDrive;
  assign illegal   = strobes.illegal;
  // write-enable-controlled writes: chip and output enables stay on
  assign ramCeN    = 1'b0;
  assign ramOeN    = 1'b0;

endmodule

// File: rtl/sharedRamCtrlChk.sv
module sharedRamCtrlChk (
  input logic clk,
  input logic rstN,
  input logic rdN,
  input logic wrN,
  input logic progMode,
  input logic progBtn,
  input logic ramWeN,
  input logic busPathEn,
  input logic busToBus,
  input logic swPathEn,
  input logic busDrive,
  input logic illegal
);

  // sampled at the falling edge, so the sampled clock level is high
  p_write_high_phase_r2: assert property (@(negedge clk) disable iff (!rstN)
    (!progMode && !wrN && rdN) |-> (!ramWeN && busPathEn && !busToBus));

  // sampled at the rising edge, so the sampled clock level is low
  p_no_write_low_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!progMode) |-> (ramWeN && !(busPathEn && !busToBus)));

  p_read_path_r4: assert property (@(negedge clk) disable iff (!rstN)
    (!progMode && !rdN) |-> (ramWeN && busPathEn && busToBus && busDrive));

  p_idle_quiet_r5: assert property (@(negedge clk) disable iff (!rstN)
    (!progMode && rdN && wrN) |-> (ramWeN && !busPathEn && !swPathEn && !busDrive));

  p_prog_bus_off_r6: assert property (@(negedge clk) disable iff (!rstN)
    progMode |-> (!busPathEn && !busDrive && (ramWeN == !progBtn)));

  p_interlock_r7: assert property (@(negedge clk) disable iff (!rstN)
    (!rdN && !wrN) |-> (illegal && (progMode || ramWeN)));

  p_turnaround_order_r11: assert property (@(negedge clk) disable iff (!rstN)
    (swPathEn || (busPathEn && !busToBus)) |-> !ramWeN);

endmodule

bind sharedRamCtrl sharedRamCtrlChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdN       (rdN),
  .wrN       (wrN),
  .progMode  (progMode),
  .progBtn   (progBtn),
  .ramWeN    (ramWeN),
  .busPathEn (busPathEn),
  .busToBus  (busToBus),
  .swPathEn  (swPathEn),
  .busDrive  (busDrive),
  .illegal   (illegal)
);

// File: tb/sharedRamCtrl_test.sv
module sharedRamCtrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic       progMode = 1'b0;
  logic       progBtn = 1'b0;
  logic [7:0] runAddr = 8'd0;
  logic [7:0] progAddr = 8'd0;
  logic [7:0] busIn = 8'd0;
  logic [7:0] swData = 8'd0;
  logic [7:0] busOut;
  logic       busDrive, ramWeN, ramCeN, ramOeN;
  logic       busPathEn, busToBus, swPathEn, illegal;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;  // 50 MHz

  sharedRamCtrl uut (
    .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .progMode(progMode),
    .progBtn(progBtn), .runAddr(runAddr), .progAddr(progAddr),
    .busIn(busIn), .swData(swData), .busOut(busOut), .busDrive(busDrive),
    .ramWeN(ramWeN), .ramCeN(ramCeN), .ramOeN(ramOeN),
    .busPathEn(busPathEn), .busToBus(busToBus), .swPathEn(swPathEn),
    .illegal(illegal)
  );

  // vector: {progMode, rdN, wrN, progBtn, expLow[5:0], expHigh[5:0]}
  // expected = {ramWeN, busPathEn, busToBus, swPathEn, busDrive, illegal}
  localparam int NVEC = 10;
  localparam logic [15:0] VECS [NVEC] = '{
    {4'b0110, 6'b100000, 6'b100000},  // R5 run idle
    {4'b0100, 6'b100000, 6'b010000},  // R2 run write
    {4'b0010, 6'b111010, 6'b111010},  // R4 run read
    {4'b0000, 6'b111011, 6'b111011},  // R7 both strobes in run
    {4'b0111, 6'b100000, 6'b100000},  // R5 button ignored in run
    {4'b1110, 6'b100000, 6'b100000},  // R6 program idle
    {4'b1111, 6'b000100, 6'b000100},  // R6 button write
    {4'b1010, 6'b100000, 6'b100000},  // R6 read strobe ignored
    {4'b1100, 6'b100000, 6'b100000},  // R6 write strobe ignored
    {4'b1000, 6'b100001, 6'b100001}   // R7 both strobes in program
  };

  function automatic logic [5:0] outVec();
    return {ramWeN, busPathEn, busToBus, swPathEn, busDrive, illegal};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic toLow();  @(negedge clk); #5; endtask
  task automatic toHigh(); @(posedge clk); #5; endtask

  task automatic runWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    progMode = 1'b0; runAddr = a; busIn = d; wrN = 1'b0; rdN = 1'b1;
    @(negedge clk); #2;          // write-enable rose at this edge
    wrN = 1'b1;
  endtask

  task automatic runRead(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); #2;
    progMode = 1'b0; runAddr = a; rdN = 1'b0; wrN = 1'b1;
    toHigh();
    check(busOut == exp && busDrive, tag, busOut, exp);
    @(negedge clk); #2;
    rdN = 1'b1;
  endtask

  initial begin
    // R9: reset holds everything off, even with write requests present
    progMode = 1'b1; progBtn = 1'b1; wrN = 1'b0;
    toHigh();
    check(ramWeN && !busPathEn && !swPathEn && !busDrive, "R9 reset prog", outVec(), 6'b100000);
    progMode = 1'b0; progBtn = 1'b0;
    toHigh();
    check(ramWeN && !busPathEn && !busDrive, "R9 reset run", outVec(), 6'b100000);
    check(ramCeN == 1'b0 && ramOeN == 1'b0, "R1 enables in reset", {ramCeN, ramOeN}, 0);
    wrN = 1'b1;
    toLow();
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk); #2;
      {progMode, rdN, wrN, progBtn} = VECS[i][15:12];
      toLow();
      check(outVec() == VECS[i][11:6], $sformatf("vec%0d low R2 R4 R5 R6 R7", i), outVec(), VECS[i][11:6]);
      toHigh();
      check(outVec() == VECS[i][5:0], $sformatf("vec%0d high R2 R4 R5 R6 R7", i), outVec(), VECS[i][5:0]);
      check(ramCeN == 1'b0 && ramOeN == 1'b0, "R1 enables", {ramCeN, ramOeN}, 0);
    end
    @(negedge clk); #2;
    {progMode, rdN, wrN, progBtn} = 4'b0110;

    // R3 R4: run writes then read back
    runWrite(8'h05, 8'hA5);
    runWrite(8'hFF, 8'h5A);
    runWrite(8'h00, 8'h11);
    runRead(8'h05, 8'hA5, "R3 R4 run read 05");
    runRead(8'hFF, 8'h5A, "R3 R4 run read FF");
    runRead(8'h00, 8'h11, "R3 R4 run read 00");

    // R8: no drive, no data on the bus
    @(negedge clk); #2; runAddr = 8'h05;
    toHigh();
    check(busOut == 8'h00 && !busDrive, "R8 gated output", busOut, 0);

    // R3 R6 R10: program write uses switch data and switch address
    @(negedge clk); #2;
    progMode = 1'b1; progAddr = 8'h09; swData = 8'h3C; runAddr = 8'h05; busIn = 8'hEE;
    progBtn = 1'b1;
    toHigh();
    check(!ramWeN && swPathEn, "R6 button write enable", outVec(), 6'b000100);
    @(negedge clk); #2; progBtn = 1'b0;
    runRead(8'h09, 8'h3C, "R3 R10 prog write at prog address");
    runRead(8'h05, 8'hA5, "R10 run address untouched by prog write");

    // R6: write strobe in program mode stores nothing
    @(negedge clk); #2;
    progMode = 1'b1; progAddr = 8'h05; runAddr = 8'h05; busIn = 8'h77; wrN = 1'b0;
    @(negedge clk); #2; wrN = 1'b1;
    runRead(8'h05, 8'hA5, "R6 strobe write ignored in program");

    // R7: both strobes in run mode read and do not write
    @(negedge clk); #2;
    progMode = 1'b0; runAddr = 8'hFF; busIn = 8'h99; rdN = 1'b0; wrN = 1'b0;
    toHigh();
    check(busOut == 8'h5A && illegal && ramWeN, "R7 interlock read", busOut, 8'h5A);
    @(negedge clk); #2; rdN = 1'b1; wrN = 1'b1;
    runRead(8'hFF, 8'h5A, "R7 no write under interlock");

    // R5: button in run mode stores nothing
    @(negedge clk); #2;
    progMode = 1'b0; progAddr = 8'h00; swData = 8'h66; progBtn = 1'b1;
    @(negedge clk); #2; progBtn = 1'b0;
    runRead(8'h00, 8'h11, "R5 button ignored in run");

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #200000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule